// File: doc/BRIEF.md
# Serial Management Bus Idle Watchdog

This block sits beside the slave state machine of a serial management bus interface. While the slave owns a transfer, the block counts coarse timebase ticks during which neither bus line changes level. If the lines stay quiet for long enough, the block concludes that the bus is stuck. It then issues a single-cycle abort so that the slave drops the transfer, lets go of the data line and returns to idle. It does not keep waiting for bytes that will never arrive.

The slave supplies synchronized copies of the clock and data lines, a flag that is high for the duration of its own transfer, and a one-millisecond tick. A configuration bit turns the watchdog off for hosts that cannot tolerate it. The bit reads 0 for enabled and resets to 0, so the watchdog is on after reset. The slave clears its transfer flag when it sees the abort pulse.

Top module: `smbus_idle_watchdog`

## Requirements
- R1: After reset `abort_o` is 0 and the idle count is zero. The lines' previous levels are taken as high.
- R2: With `xfer_busy`=1 and `tmo_disable`=0, the cycle after the LIMIT_TICKS-th (default 25) consecutive `tick_i` with no line edge, `abort_o` is 1.
- R3: A level change on `scl_i` or on `sda_i` (compared with the previous cycle) restarts the idle count. A tick that arrives in the same cycle as an edge is not counted.
- R4: While `xfer_busy`=0 the count is held at zero, so ticks outside a transfer never contribute to an abort.
- R5: `tmo_disable`=1 means disabled and 0 means enabled. While it is 1 no abort is produced and the count is cleared.
- R6: `abort_o` lasts exactly one cycle. At most one abort occurs per transfer; the count re-arms only after `xfer_busy` returns to 0.
- R7: Every abort follows between MIN_TICKS (15) and MAX_TICKS (35) quiet ticks of the current transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronized bus clock line |
| sda_i | input | 1 | Synchronized bus data line |
| xfer_busy | input | 1 | High while this slave owns a transfer |
| tick_i | input | 1 | One-cycle pulse every millisecond |
| tmo_disable | input | 1 | Configuration bit: 1 turns the watchdog off |
| abort_o | output | 1 | One-cycle pulse telling the slave to release the bus |

## Verification
The bench targets the exact tick on which the abort appears. A counter off by one would fire one tick early or one tick late. It places a line edge in the same cycle as a tick, where a design that counted that tick would abort one tick too soon. It keeps `xfer_busy` high for long after an abort, where a design that re-armed at once would pulse again every 25 ticks. It flips `tmo_disable` mid-count and runs ticks outside a transfer; a design that kept the stale count would abort early once it was enabled again.

// File: rtl/smbus_idle_watchdog.sv
module smbus_idle_watchdog #(
  parameter int LIMIT_TICKS = 25,
  parameter int MIN_TICKS   = 15,
  parameter int MAX_TICKS   = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic xfer_busy,
  input  logic tick_i,
  input  logic tmo_disable,
  output logic abort_o
);
  localparam int CW = $clog2(LIMIT_TICKS + 1);
  localparam int SW = $clog2(MAX_TICKS + 2);

  logic          scl_q, sda_q, fired;
  logic [CW-1:0] idle_cnt;
  logic          bus_edge, armed, expire;

  assign bus_edge = (scl_i ^ scl_q) | (sda_i ^ sda_q);
  assign armed    = xfer_busy & ~tmo_disable & ~fired;
  assign expire   = armed & ~bus_edge & tick_i & (idle_cnt == CW'(LIMIT_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          idle_cnt <= '0;
    else if (!armed || bus_edge || expire) idle_cnt <= '0;
    else if (tick_i)                     idle_cnt <= idle_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          fired <= 1'b0;
    else if (!xfer_busy) fired <= 1'b0;
    else if (expire)     fired <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) abort_o <= 1'b0;
    else        abort_o <= expire;
  end

  // shadow count of quiet ticks, for the window check
  logic [SW-1:0] quiet_sh;
  always_ff @(posedge clk) begin
    if (!rst_n)                                   quiet_sh <= '0;
    else if (!xfer_busy || tmo_disable || bus_edge) quiet_sh <= '0;
    else if (tick_i && quiet_sh <= SW'(MAX_TICKS)) quiet_sh <= quiet_sh + 1'b1;
  end

  p_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (quiet_sh >= SW'(MIN_TICKS) && quiet_sh <= SW'(MAX_TICKS)));

  p_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o);

  p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> !$past(tmo_disable));

  p_only_in_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> $past(xfer_busy));

  p_no_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> $past(scl_i == scl_q && sda_i == sda_q));

  p_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> $past(tick_i));
endmodule

// File: tb/test_smbus_idle_watchdog.sv
module test_smbus_idle_watchdog;
  localparam int LIMIT = 25;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, busy = 1'b0, tick = 1'b0, dis = 1'b0;
  logic abort_o;

  int checks = 0, errors = 0, cycles = 0, aborts = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  smbus_idle_watchdog i_smbus_idle_watchdog (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .xfer_busy(busy),
    .tick_i(tick), .tmo_disable(dis), .abort_o(abort_o));

  // behavioural reference model
  int quiet = 0;
  bit done_once = 0, prev_scl = 1, prev_sda = 1, exp_abort = 0;
  always @(posedge clk) begin
    bit edge_seen;
    if (!rst_n) begin
      quiet = 0; done_once = 0; prev_scl = 1; prev_sda = 1; exp_abort = 0;
    end else begin
      edge_seen = (scl != prev_scl) || (sda != prev_sda);
      exp_abort = 0;
      if (!busy) begin quiet = 0; done_once = 0; end
      else if (dis || done_once || edge_seen) quiet = 0;
      else if (tick) begin
        quiet++;
        if (quiet == LIMIT) begin exp_abort = 1; done_once = 1; quiet = 0; end
      end
      prev_scl = scl; prev_sda = sda;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (abort_o) aborts++;
    if (rst_n) check(cur_req, abort_o, exp_abort);
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic cyc(bit tk);
    @(negedge clk); tick = tk;
  endtask

  task automatic run_ticks(int n);
    for (int i = 0; i < n; i++) begin
      cyc(0); cyc(0); cyc(0); cyc(1);
    end
    cyc(0);
  endtask

  initial begin
    int base;
    repeat (3) cyc(0);
    rst_n = 1'b1;
    cyc(0);
    check("R1", abort_o, 0);

    // R2: exact firing tick
    cur_req = "R2"; busy = 1; base = aborts;
    run_ticks(LIMIT - 1);
    check("R2", aborts - base, 0);
    run_ticks(1); cyc(0);
    check("R2", aborts - base, 1);
    busy = 0; cyc(0); cyc(0);

    // R3: edges restart, including edge on a tick
    cur_req = "R3"; busy = 1; base = aborts;
    run_ticks(20); @(negedge clk); scl = ~scl;
    run_ticks(20); @(negedge clk); sda = ~sda;
    run_ticks(20);
    @(negedge clk); sda = ~sda; tick = 1; cyc(0);
    run_ticks(LIMIT - 1); cyc(0);
    check("R3", aborts - base, 0);
    run_ticks(1); cyc(0);
    check("R3", aborts - base, 1);
    busy = 0; cyc(0);

    // R4: ticks outside a transfer do not accumulate
    cur_req = "R4"; base = aborts;
    run_ticks(40);
    busy = 1; run_ticks(LIMIT - 5);
    check("R4", aborts - base, 0);
    busy = 0; cyc(0);

    // R5: disable suppresses and clears
    cur_req = "R5"; base = aborts; busy = 1;
    run_ticks(20); dis = 1; run_ticks(40);
    check("R5", aborts - base, 0);
    dis = 0; run_ticks(20);
    check("R5", aborts - base, 0);
    run_ticks(5); cyc(0);
    check("R5", aborts - base, 1);
    busy = 0; cyc(0);

    // R6: one abort per transfer, re-arms after busy drops
    cur_req = "R6"; base = aborts; busy = 1;
    run_ticks(LIMIT * 3);
    check("R6", aborts - base, 1);
    busy = 0; cyc(0); busy = 1;
    run_ticks(LIMIT); cyc(0);
    check("R6", aborts - base, 2);
    busy = 0; cyc(0);

    // R7: abort never before the minimum quiet window
    cur_req = "R7"; base = aborts; busy = 1;
    run_ticks(15);
    check("R7", aborts - base, 0);
    run_ticks(20);
    check("R7", aborts - base, 1);
    busy = 0;
    repeat (4) cyc(0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule